// File: doc/BRIEF.md
# Doorbell and Message Interrupt Unit

This unit lets software on any of several CPUs ring doorbells on other CPUs, and gives peripherals one fixed address where they can post message-signalled interrupts. A single write to the shared trigger register names a doorbell number and a set of target CPUs. The doorbell bit is then set in the pending register of each named CPU. Every CPU owns a 32-bit pending (cause) register and a 32-bit enable (mask) register. The low group of doorbells (0 to 7) carries inter-processor messages. The high group (16 to 31) carries message-signalled interrupts. Doorbells 8 to 15 are reserved.

For each CPU the unit drives two level outputs into the interrupt controller, one for each group. An output is high while any pending bit of its group is also enabled. A handler clears its pending bits by writing zero to them; writing one leaves a bit as it is. A peripheral raises message interrupt k by writing `0xF00 | (k + 16)` to the trigger address. Every CPU bit is set in that value, so all CPUs see the doorbell.

The register bus is a simple request/acknowledge port. A small state machine has two states, IDLE and ACK. In IDLE, a request is accepted: a write takes effect at that clock edge and read data is captured (transition IDLE→ACK). ACK drives the acknowledge for exactly one cycle and always returns to IDLE (transition ACK→IDLE). A request seen in IDLE with no request pending keeps the machine in IDLE. The requester drops its request in the cycle it sees the acknowledge.

Top module: `db_unit`

## Requirements
- R1: After reset every cause and mask register reads zero, every summary output is low and `bus_ack` is low.
- R2: A request accepted in IDLE produces `bus_ack` high for exactly one cycle, in the cycle after acceptance. Read data is valid while `bus_ack` is high.
- R3: A write to the trigger address (0x004) with doorbell number n = `wdata[4:0]` sets cause bit n of every CPU c whose bit `wdata[8+c]` is one. All other cause bits and all untargeted CPUs keep their values.
- R4: A trigger with n in 8..15 sets nothing. Cause bits 8..15 always read zero.
- R5: A write to a CPU's cause register clears each bit written as zero and keeps each bit written as one. Writing zero clears every pending doorbell of that CPU.
- R6: A write to a CPU's mask register stores all 32 bits, which read back unchanged. Mask registers of other CPUs do not change.
- R7: `ipi_irq[c]` is high exactly when (cause & mask) of CPU c is nonzero in bits 7..0.
- R8: `msi_irq[c]` is high exactly when (cause & mask) of CPU c is nonzero in bits 31..16.
- R9: A trigger write of `0xF00 | (k+16)` for k in 0..15 sets cause bit k+16 in all four CPUs.
- R10: CPU c's cause register is at 0x100 + 16c + 0x8 and its mask register at 0x100 + 16c + 0xC. The trigger address and any unmapped address read zero. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| ipi_irq | output | 4 | Per-CPU inter-processor summary |
| msi_irq | output | 4 | Per-CPU message-interrupt summary |

## Verification
The bench builds the unit with its defaults: four CPUs, a 10-bit address and the 0–7 and 16–31 doorbell groups. With these values every target map from empty to all four CPUs can be drawn, and so can every doorbell number, including the reserved middle range. The first unmapped per-CPU window at 0x140 also sits inside the address space, so stray writes there can be observed. Random triggers, partial clears and mask changes are mixed so that both summaries of every CPU rise and fall through both paths: a new pending bit, and a change of enable.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int DATA_W   = 32;
    localparam int DBNUM_W  = 5;
    localparam int MAP_LSB  = 8;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } bus_state_t;

    // Bits that belong to one of the two doorbell groups.
    function automatic logic [DATA_W-1:0] group_bits(input int lo, input int n);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= lo && i < lo + n) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/db_bus_fsm.sv
module db_bus_fsm
    import db_pkg::*;
#(
    parameter int NCPU        = 4,
    parameter int ADDR_W      = 10,
    parameter int TRIG_OFFS   = 4,
    parameter int PCPU_BASE   = 256,
    parameter int PCPU_STRIDE = 16,
    parameter int CAUSE_OFFS  = 8,
    parameter int MASK_OFFS   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NCPU-1:0][DATA_W-1:0] cause_all,
    input  logic [NCPU-1:0][DATA_W-1:0] mask_all,
    output logic                        trig_we,
    output logic [NCPU-1:0]             cause_we,
    output logic [NCPU-1:0]             mask_we,
    output logic                        ack,
    output logic [DATA_W-1:0]           rdata
);

    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFFS);

    bus_state_t state_q, state_d;
    logic       accept;
    logic       hit_trig;
    logic [NCPU-1:0] sel_cause, sel_mask;
    logic [DATA_W-1:0] rd_mux;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req) state_d = S_ACK;
            S_ACK:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign accept = (state_q == S_IDLE) && req;

    // Address decode
    always_comb begin
        hit_trig  = (addr == TRIG_A);
        sel_cause = '0;
        sel_mask  = '0;
        for (int c = 0; c < NCPU; c++) begin
            sel_cause[c] = (addr == ADDR_W'(PCPU_BASE + c*PCPU_STRIDE + CAUSE_OFFS));
            sel_mask[c]  = (addr == ADDR_W'(PCPU_BASE + c*PCPU_STRIDE + MASK_OFFS));
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (sel_cause[c]) rd_mux = rd_mux | cause_all[c];
            if (sel_mask[c])  rd_mux = rd_mux | mask_all[c];
        end
    end

    assign trig_we  = accept && we && hit_trig;
    assign cause_we = (accept && we) ? sel_cause : '0;
    assign mask_we  = (accept && we) ? sel_mask  : '0;

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= accept;
            if (accept) rdata <= we ? '0 : rd_mux;
        end
    end

    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req) |=> ack);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({trig_we, cause_we, mask_we}) <= 1);

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int CPU_ID = 0,
    parameter int IPI_LO = 0,
    parameter int IPI_N  = 8,
    parameter int MSI_LO = 16,
    parameter int MSI_N  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_we,
    input  logic [DBNUM_W-1:0] trig_num,
    input  logic [NCPU-1:0]    trig_map,
    input  logic               cause_we,
    input  logic               mask_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  cause,
    output logic [DATA_W-1:0]  mask,
    output logic               ipi_irq,
    output logic               msi_irq
);

    localparam logic [DATA_W-1:0] IPI_BITS  = group_bits(IPI_LO, IPI_N);
    localparam logic [DATA_W-1:0] MSI_BITS  = group_bits(MSI_LO, MSI_N);
    localparam logic [DATA_W-1:0] LIVE_BITS = IPI_BITS | MSI_BITS;

    logic              set_hit;
    logic [DATA_W-1:0] cause_d;
    logic [DATA_W-1:0] armed;

    assign set_hit = trig_we && trig_map[CPU_ID] && LIVE_BITS[trig_num];

    // Clear first, then set, so a simultaneous set wins.
    always_comb begin
        cause_d = cause;
        if (cause_we) cause_d = cause & wdata;
        if (set_hit)  cause_d[trig_num] = 1'b1;
        cause_d = cause_d & LIVE_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            cause <= cause_d;
            if (mask_we) mask <= wdata;
        end
    end

    assign armed   = cause & mask;
    assign ipi_irq = |(armed & IPI_BITS);
    assign msi_irq = |(armed & MSI_BITS);

    a_r3_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> cause[$past(trig_num)]);
    a_r5_write_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && !set_hit) |=> ((cause & ~$past(cause)) == '0));
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
    a_r7_ipi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ipi_irq) |-> ($past(set_hit) || $past(mask_we)));
    a_r8_msi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_irq) |-> ($past(set_hit) || $past(mask_we)));

endmodule

// File: rtl/db_unit.sv
module db_unit
    import db_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 10,
    parameter int IPI_LO = 0,
    parameter int IPI_N  = 8,
    parameter int MSI_LO = 16,
    parameter int MSI_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   msi_irq
);

    logic                        trig_we;
    logic [NCPU-1:0]             cause_we, mask_we;
    logic [NCPU-1:0][DATA_W-1:0] cause_all, mask_all;
    logic [DBNUM_W-1:0]          trig_num;
    logic [NCPU-1:0]             trig_map;

    assign trig_num = bus_wdata[DBNUM_W-1:0];
    assign trig_map = bus_wdata[MAP_LSB +: NCPU];

    db_bus_fsm #(
        .NCPU   (NCPU),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .cause_all (cause_all),
        .mask_all  (mask_all),
        .trig_we   (trig_we),
        .cause_we  (cause_we),
        .mask_we   (mask_we),
        .ack       (bus_ack),
        .rdata     (bus_rdata)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        db_cpu_bank #(
            .NCPU   (NCPU),
            .CPU_ID (c),
            .IPI_LO (IPI_LO),
            .IPI_N  (IPI_N),
            .MSI_LO (MSI_LO),
            .MSI_N  (MSI_N)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_we  (trig_we),
            .trig_num (trig_num),
            .trig_map (trig_map),
            .cause_we (cause_we[c]),
            .mask_we  (mask_we[c]),
            .wdata    (bus_wdata),
            .cause    (cause_all[c]),
            .mask     (mask_all[c]),
            .ipi_irq  (ipi_irq[c]),
            .msi_irq  (msi_irq[c])
        );
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (ipi_irq == '0 && msi_irq == '0 && !bus_ack));

endmodule

// File: tb/db_unit_tb.sv
module db_unit_tb;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [NCPU-1:0] ipi_irq, msi_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    logic [31:0] m_cause [NCPU];
    logic [31:0] m_mask  [NCPU];

    db_unit u_dut (
        .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ack (bus_ack),
        .bus_rdata (bus_rdata), .ipi_irq (ipi_irq), .msi_irq (msi_irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [9:0] cause_a(input int c); return 10'(256 + 16*c + 8);  endfunction
    function automatic logic [9:0] mask_a(input int c);  return 10'(256 + 16*c + 12); endfunction
    function automatic logic exp_ipi(input int c); return |(m_cause[c] & m_mask[c] & 32'h0000_00FF); endfunction
    function automatic logic exp_msi(input int c); return |(m_cause[c] & m_mask[c] & 32'hFFFF_0000); endfunction

    task automatic bus_op(input logic w, input logic [9:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        check("R2 idle ack low", {31'b0, bus_ack}, 32'd0);
        bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        check("R2 ack", {31'b0, bus_ack}, 32'd1);
        rd = bus_rdata;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // Model updates
    task automatic do_trig(input logic [31:0] d);
        logic [31:0] rd;
        bus_op(1'b1, 10'h004, d, rd);
        for (int c = 0; c < NCPU; c++)
            if (d[8+c] && !(d[4:0] >= 8 && d[4:0] <= 15)) m_cause[c][d[4:0]] = 1'b1;
    endtask

    task automatic do_clear(input int c, input logic [31:0] d);
        logic [31:0] rd;
        bus_op(1'b1, cause_a(c), d, rd);
        m_cause[c] = m_cause[c] & d;
    endtask

    task automatic do_mask(input int c, input logic [31:0] d);
        logic [31:0] rd;
        bus_op(1'b1, mask_a(c), d, rd);
        m_mask[c] = d;
    endtask

    task automatic check_irqs(input string tag);
        for (int c = 0; c < NCPU; c++) begin
            check({tag, " R7 ipi"}, {31'b0, ipi_irq[c]}, {31'b0, exp_ipi(c)});
            check({tag, " R8 msi"}, {31'b0, msi_irq[c]}, {31'b0, exp_msi(c)});
        end
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] rd;
        for (int c = 0; c < NCPU; c++) begin
            bus_op(1'b0, cause_a(c), 32'h0, rd);
            check({tag, " cause"}, rd, m_cause[c]);
            bus_op(1'b0, mask_a(c), 32'h0, rd);
            check({tag, " mask"}, rd, m_mask[c]);
        end
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h0D00_B311));
        for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack", {31'b0, bus_ack}, 32'd0);
        check_irqs("R1");
        check_regs("R1");

        // R6 mask readback, all bits
        for (int c = 0; c < NCPU; c++) do_mask(c, 32'hFFFF_FFFF);
        check_regs("R6");

        // R3 targeted doorbell to CPUs 1 and 3
        do_trig(32'h0000_0A03);
        check_irqs("R3");
        check_regs("R3");

        // R4 reserved doorbells set nothing
        for (int n = 8; n < 16; n++) do_trig(32'h0000_0F00 | 32'(n));
        check_regs("R4");

        // R9 message writes reach all CPUs
        for (int k = 0; k < 16; k += 5) do_trig(32'h0000_0F00 | 32'(k + 16));
        check_irqs("R9");
        check_regs("R9");

        // R5 partial clear, then full clear
        do_clear(1, 32'hFFFF_FFF7);
        do_clear(2, 32'h0);
        check_regs("R5");
        check_irqs("R5");

        // R10 trigger and unmapped reads zero, unmapped write ignored
        bus_op(1'b0, 10'h004, 32'h0, rd);
        check("R10 trig read", rd, 32'h0);
        bus_op(1'b1, 10'h140, 32'h0, rd);
        bus_op(1'b1, 10'h000, 32'h0, rd);
        bus_op(1'b0, 10'h140, 32'h0, rd);
        check("R10 unmapped read", rd, 32'h0);
        check_regs("R10");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            int c;
            op = int'($urandom_range(0, 3));
            c  = int'($urandom_range(0, NCPU-1));
            unique case (op)
                0: do_trig({20'h0, 4'($urandom_range(0, 15)), 3'b0, 5'($urandom_range(0, 31))});
                1: do_trig(32'h0000_0F00 | 32'($urandom_range(16, 31)));
                2: do_clear(c, $urandom() | $urandom());
                default: do_mask(c, $urandom() & $urandom());
            endcase
            @(negedge clk);
            check_irqs("R7 R8 rand");
            if (i % 20 == 0) check_regs("R3 R5 rand");
        end

        for (int c = 0; c < NCPU; c++) do_clear(c, 32'h0);
        check_irqs("R5 final");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule